// File: doc/BRIEF.md
# External Chip-Select Decoder with Per-Area Wait Control

This block watches the 20-bit external bus address of a 1 MB address space and drives four active-low chip-select lines, one for each external memory area. The area boundaries depend on the processor mode and, in memory-expansion mode, on an area-expansion flag. A byte-wide control register holds two bits for each select. One bit decides whether the matching pin carries the chip select or is left to the port logic. The other bit decides whether accesses to that area need a software wait state.

The bus sequencer marks each external access with `bus_active`, which stays high for the whole access, and `bus_start`, which is high only on its first cycle. One cycle later the block drives the decoded select low, as long as that select's pin is enabled. On the same cycle it raises `wait_req` for a single cycle if the decoded area asks for a wait. In single-chip mode every pin reverts to port use and nothing is decoded, whatever the register holds.

Top module: `csd_top`

## Requirements
- R1: After synchronous reset the control register reads 0x01, every `cs_n` bit is 1, `pin_is_cs` is 0 and `wait_req` is 0.
- R2: When `reg_wr` is high at a clock edge, `reg_wdata` is stored, and `reg_rdata` returns all 8 bits from then on.
- R3: Register bit i (i = 0..3) is the pin-enable of select i. One cycle after the register or `mode` changes, `pin_is_cs[i]` equals that bit in the external modes (`mode` 2'b01 memory-expansion, 2'b10 microprocessor). In the single-chip modes (`mode` 2'b00, and the reserved 2'b11) it is 0.
- R4: In both external modes, select 3 covers 0x04000–0x07FFF, select 2 covers 0x08000–0x27FFF and select 1 covers 0x28000–0x2FFFF, with both ends inclusive.
- R5: In memory-expansion mode, select 0 covers 0x30000–0xCFFFF when `area_ext` is 0 and 0x30000–0xF7FFF when `area_ext` is 1.
- R6: In microprocessor mode, select 0 covers 0x30000–0xFFFFF whatever the value of `area_ext`.
- R7: `cs_n[i]` is 0 in the cycle after a clock edge at which all of these hold: `bus_active` is high, the address lies in window i, pin-enable bit i is 1, and the mode is external. Otherwise it is 1. At most one select is low at any time.
- R8: Register bit 4+i is the wait bit of select i, where 0 means insert a wait. `wait_req` is high for exactly one cycle, the cycle after an edge with `bus_start` high, an external mode and an address in a window whose wait bit is 0. This holds whatever the state of that select's pin-enable bit.
- R9: In the single-chip modes no select goes low and `wait_req` stays 0 for any address.
- R10: Addresses below 0x04000 assert no select and no wait request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| mode | input | 2 | Processor mode: 00 single-chip, 01 memory-expansion, 10 microprocessor, 11 reserved (treated as single-chip) |
| area_ext | input | 1 | Extends the select-0 area in memory-expansion mode |
| bus_active | input | 1 | External access in progress |
| bus_start | input | 1 | First cycle of an external access |
| bus_addr | input | 20 | External bus address |
| cs_n | output | 4 | Active-low chip selects, registered |
| pin_is_cs | output | 4 | 1 = pin carries its chip select, 0 = pin left to port logic |
| wait_req | output | 1 | One-cycle wait request to the bus sequencer |

## Verification
The hardest case to reach is the top edge of select 0. Here the same address, 0xF7FFF or 0xF8000, has to fall inside or outside the window depending on both `mode` and `area_ext`. The stimulus runs one list of boundary addresses, with both ends of every window and the first address past each, through all four combinations of the external modes and the flag. A second hard case is a wait request from an area whose pin is disabled. To reach it, the register is written with every enable bit cleared and every wait bit set to "insert". Each access must then produce `wait_req` while `cs_n` stays high.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic [1:0] {
    PM_SINGLE = 2'b00,
    PM_EXPAND = 2'b01,
    PM_MICRO  = 2'b10,
    PM_RSVD   = 2'b11
  } proc_mode_e;

  localparam int unsigned CSD_AW   = 20;
  localparam int unsigned CSD_NSEL = 4;

  // window lower bounds per select
  function automatic logic [CSD_AW-1:0] win_lo(input int unsigned idx);
    case (idx)
      0:       return 20'h30000;
      1:       return 20'h28000;
      2:       return 20'h08000;
      default: return 20'h04000;
    endcase
  endfunction

  // window upper bounds per select; select 0 entry is a placeholder (mode dependent)
  function automatic logic [CSD_AW-1:0] win_hi(input int unsigned idx);
    case (idx)
      0:       return 20'hCFFFF;
      1:       return 20'h2FFFF;
      2:       return 20'h27FFF;
      default: return 20'h07FFF;
    endcase
  endfunction

  function automatic logic is_external(input logic [1:0] m);
    return (m == PM_EXPAND) || (m == PM_MICRO);
  endfunction
endpackage

// File: rtl/csd_ctrl_reg.sv
module csd_ctrl_reg #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/csd_window.sv
module csd_window #(
  parameter int unsigned AW = 20
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);
  always_comb hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/csd_sel_out.sv
module csd_sel_out #(
  parameter int unsigned NSEL = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_mode,
  input  logic [NSEL-1:0] pin_en,
  input  logic [NSEL-1:0] wait_bits,
  input  logic [NSEL-1:0] hits,
  input  logic            bus_active,
  input  logic            bus_start,
  output logic [NSEL-1:0] cs_n,
  output logic [NSEL-1:0] pin_is_cs,
  output logic            wait_req
);
  logic [NSEL-1:0] sel_d;
  logic [NSEL-1:0] wreq_d;

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    always_comb begin
      sel_d[i]  = ext_mode && bus_active && hits[i] && pin_en[i];
      wreq_d[i] = ext_mode && bus_start && hits[i] && !wait_bits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n      <= '1;
      pin_is_cs <= '0;
      wait_req  <= 1'b0;
    end else begin
      cs_n      <= ~sel_d;
      pin_is_cs <= ext_mode ? pin_en : '0;
      wait_req  <= |wreq_d;
    end
  end
endmodule

// File: rtl/csd_top.sv
module csd_top
  import csd_pkg::*;
#(
  parameter int unsigned ADDR_W = CSD_AW,
  parameter int unsigned NSEL   = CSD_NSEL,
  parameter int unsigned REG_W  = 2 * NSEL,
  parameter logic [REG_W-1:0] REG_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [1:0]        mode,
  input  logic              area_ext,
  input  logic              bus_active,
  input  logic              bus_start,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NSEL-1:0]   cs_n,
  output logic [NSEL-1:0]   pin_is_cs,
  output logic              wait_req
);
  localparam logic [ADDR_W-1:0] S0_HI_EXP  = ADDR_W'(20'hCFFFF);
  localparam logic [ADDR_W-1:0] S0_HI_EXPX = ADDR_W'(20'hF7FFF);
  localparam logic [ADDR_W-1:0] S0_HI_MIC  = ADDR_W'(20'hFFFFF);

  logic [REG_W-1:0]  ctrl_q;
  logic [NSEL-1:0]   hits;
  logic              ext_mode;
  logic [ADDR_W-1:0] s0_hi;

  csd_ctrl_reg #(.W(REG_W), .RST_VAL(REG_RST)) u_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata), .q(ctrl_q)
  );

  always_comb begin
    ext_mode = is_external(mode);
    if (mode == PM_MICRO)  s0_hi = S0_HI_MIC;
    else if (area_ext)     s0_hi = S0_HI_EXPX;
    else                   s0_hi = S0_HI_EXP;
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_win
    logic [ADDR_W-1:0] hi_i;
    if (i == 0) begin : g_var
      always_comb hi_i = s0_hi;
    end else begin : g_fix
      always_comb hi_i = ADDR_W'(win_hi(i));
    end
    csd_window #(.AW(ADDR_W)) u_win (
      .addr(bus_addr), .lo(ADDR_W'(win_lo(i))), .hi(hi_i), .hit(hits[i])
    );
  end

  csd_sel_out #(.NSEL(NSEL)) u_out (
    .clk(clk), .rst(rst), .ext_mode(ext_mode),
    .pin_en(ctrl_q[NSEL-1:0]), .wait_bits(ctrl_q[REG_W-1:NSEL]),
    .hits(hits), .bus_active(bus_active), .bus_start(bus_start),
    .cs_n(cs_n), .pin_is_cs(pin_is_cs), .wait_req(wait_req)
  );

  always_comb reg_rdata = ctrl_q;
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int unsigned NSEL  = 4,
  parameter int unsigned REG_W = 8,
  parameter logic [REG_W-1:0] REG_RST = 8'h01
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [1:0]       mode,
  input logic             bus_active,
  input logic             bus_start,
  input logic [NSEL-1:0]  cs_n,
  input logic [NSEL-1:0]  pin_is_cs,
  input logic             wait_req
);
  assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (reg_rdata == REG_RST && (&cs_n) && pin_is_cs == '0 && !wait_req));

  assert_write_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_wr) && !$past(rst)) |-> reg_rdata == $past(reg_wdata));

  assert_pin_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 2'b01 || $past(mode) == 2'b10))
      |-> pin_is_cs == $past(reg_rdata[NSEL-1:0]));

  assert_single_select_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_active) |-> (&cs_n));

  assert_wait_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_start) |-> !wait_req);

  assert_single_chip_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b00 || $past(mode) == 2'b11)
      |-> ((&cs_n) && pin_is_cs == '0 && !wait_req));
endmodule

bind csd_top csd_checker #(.NSEL(NSEL), .REG_W(REG_W), .REG_RST(REG_RST)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .mode(mode), .bus_active(bus_active), .bus_start(bus_start),
  .cs_n(cs_n), .pin_is_cs(pin_is_cs), .wait_req(wait_req)
);

// File: tb/sim_csd_top.sv
`timescale 1ns/1ps
module sim_csd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [1:0]  mode = 2'b01;
  logic        area_ext = 1'b0;
  logic        bus_active = 1'b0;
  logic        bus_start = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [3:0]  cs_n;
  logic [3:0]  pin_is_cs;
  logic        wait_req;

  int checks = 0;
  int errors = 0;
  logic [7:0] cur_reg = 8'h01;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csd_top u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mode(mode), .area_ext(area_ext), .bus_active(bus_active), .bus_start(bus_start),
    .bus_addr(bus_addr), .cs_n(cs_n), .pin_is_cs(pin_is_cs), .wait_req(wait_req)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_hit(input logic [19:0] a, input logic [1:0] m, input logic x);
    logic [3:0] h = '0;
    logic [19:0] top0;
    if (m != 2'b01 && m != 2'b10) return 4'b0;
    top0 = (m == 2'b10) ? 20'hFFFFF : (x ? 20'hF7FFF : 20'hCFFFF);
    if (a >= 20'h04000 && a <= 20'h07FFF) h[3] = 1'b1;
    if (a >= 20'h08000 && a <= 20'h27FFF) h[2] = 1'b1;
    if (a >= 20'h28000 && a <= 20'h2FFFF) h[1] = 1'b1;
    if (a >= 20'h30000 && a <= top0)      h[0] = 1'b1;
    return h;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    step();
    reg_wr = 1'b0;
    cur_reg = v;
  endtask

  task automatic access(input logic [19:0] a, input string tag);
    logic [3:0] h = exp_hit(a, mode, area_ext);
    logic [3:0] ecs = ~(h & cur_reg[3:0]);
    logic ew = |(h & ~cur_reg[7:4]);
    bus_addr = a; bus_active = 1'b1; bus_start = 1'b1;
    step();
    check(cs_n == ecs, {tag, " cs_n first cycle"}, cs_n, ecs);
    check(wait_req == ew, {tag, " R8 wait_req"}, wait_req, ew);
    bus_start = 1'b0;
    step();
    check(cs_n == ecs, {tag, " R7 cs_n held"}, cs_n, ecs);
    check(wait_req == 1'b0, {tag, " R8 single pulse"}, wait_req, 0);
    bus_active = 1'b0;
    step();
    check(cs_n == 4'hF, {tag, " R7 idle high"}, cs_n, 4'hF);
  endtask

  task automatic t_reset();
    check(reg_rdata == 8'h01, "R1 reg reset", reg_rdata, 8'h01);
    check(cs_n == 4'hF, "R1 cs_n reset", cs_n, 4'hF);
    check(pin_is_cs == 4'h0, "R1 pin reset", pin_is_cs, 0);
    check(wait_req == 1'b0, "R1 wait reset", wait_req, 0);
  endtask

  task automatic t_regrw();
    write_reg(8'hA5);
    check(reg_rdata == 8'hA5, "R2 readback A5", reg_rdata, 8'hA5);
    write_reg(8'h5A);
    check(reg_rdata == 8'h5A, "R2 readback 5A", reg_rdata, 8'h5A);
    step();
    check(reg_rdata == 8'h5A, "R2 hold", reg_rdata, 8'h5A);
  endtask

  task automatic t_pins();
    write_reg(8'h0B);
    mode = 2'b01; step();
    check(pin_is_cs == 4'hB, "R3 expand pins", pin_is_cs, 4'hB);
    mode = 2'b00; step();
    check(pin_is_cs == 4'h0, "R3 single pins", pin_is_cs, 0);
    mode = 2'b11; step();
    check(pin_is_cs == 4'h0, "R3 reserved pins", pin_is_cs, 0);
    mode = 2'b10; step();
    check(pin_is_cs == 4'hB, "R3 micro pins", pin_is_cs, 4'hB);
    write_reg(8'h04); step();
    check(pin_is_cs == 4'h4, "R3 pins after write", pin_is_cs, 4'h4);
  endtask

  task automatic t_windows();
    logic [19:0] pts [13] = '{20'h03FFF, 20'h04000, 20'h07FFF, 20'h08000, 20'h27FFF,
                             20'h28000, 20'h2FFFF, 20'h30000, 20'hCFFFF, 20'hD0000,
                             20'hF7FFF, 20'hF8000, 20'hFFFFF};
    write_reg(8'hFF);
    for (int m = 1; m <= 2; m++) begin
      for (int x = 0; x <= 1; x++) begin
        mode = 2'(m); area_ext = x[0];
        step();
        for (int k = 0; k < 13; k++) begin
          if (pts[k] < 20'h04000)      access(pts[k], "R10");
          else if (pts[k] < 20'h30000) access(pts[k], "R4");
          else if (m == 1)             access(pts[k], "R5");
          else                         access(pts[k], "R6");
        end
      end
    end
    area_ext = 1'b0;
  endtask

  task automatic t_wait();
    mode = 2'b01;
    write_reg(8'h0F);
    access(20'h05000, "R8 wait s3");
    access(20'h10000, "R8 wait s2");
    access(20'h2A000, "R8 wait s1");
    access(20'h40000, "R8 wait s0");
    write_reg(8'hAF);
    access(20'h40000, "R8 mixed s0");
    access(20'h2A000, "R8 mixed s1");
    access(20'h10000, "R8 mixed s2");
    access(20'h05000, "R8 mixed s3");
    write_reg(8'h00);
    access(20'h40000, "R8 disabled pin s0");
    access(20'h05000, "R8 disabled pin s3");
    access(20'h01000, "R10 low no wait");
  endtask

  task automatic t_single();
    write_reg(8'h0F);
    mode = 2'b00; step();
    access(20'h40000, "R9 single s0");
    access(20'h05000, "R9 single s3");
    mode = 2'b11; step();
    access(20'h2A000, "R9 reserved s1");
    bus_addr = 20'h40000; bus_active = 1'b1; bus_start = 1'b1;
    step();
    check(cs_n == 4'hF && wait_req == 1'b0, "R9 direct", {cs_n, 3'b0, wait_req}, 32'hF0);
    bus_active = 1'b0; bus_start = 1'b0;
    step();
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    t_reset();
    t_regrw();
    t_pins();
    t_windows();
    t_wait();
    t_single();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule